// File: doc/BRIEF.md
# SD Special-Command Payload Reorder Unit

This unit sits on the receive side of an SD host, between the card data path and the system side. A few SD commands return a data payload whose byte or bit order differs from ordinary data blocks. The unit rewrites each 32-bit payload word into the order the protocol expects, so software sees consistent data. All other traffic passes through untouched.

A transfer opens with a one-cycle `xfer_start` strobe. On that strobe the unit samples the command index, the addressed-data-transfer flag, the block count and the block size. It keeps the chosen transform until the one-cycle `xfer_end` strobe. Between the two strobes, words flow in on a valid/ready input stream. They leave through one registered stage on a valid/ready output stream.

The payload length is known in advance: block count times block size divided by four. The unit accepts no words beyond that length. If the transfer closes with fewer words, the unit flags the mismatch. If the block size is not a whole number of words, the unit refuses the transfer.

Top module: `sd_payload_reorder`

## Requirements
- R1: After reset, `busy`, `out_valid`, `in_ready`, `size_err` and `len_err` are all 0.
- R2: With `adtc`=1 and `cmd_idx`=6 at the start strobe, every output word keeps its byte positions, and the bit order inside each byte is reversed (input bit 8b+k goes to output bit 8b+7-k).
- R3: With `adtc`=1 and `cmd_idx` equal to 13, 22, 30 or 51 at the start strobe, every output word has its four bytes in reverse order (input bits [7:0] go to output bits [31:24], and so on).
- R4: With any other index, or with `adtc`=0, output words equal input words.
- R5: A start strobe while idle, with `blk_size[1:0]` not 00, sets `size_err` one cycle later, leaves `busy` at 0 and keeps `in_ready` low. The next accepted start clears `size_err`.
- R6: While `busy` is 1, the transform is fixed. Changes to `cmd_idx` or `adtc`, and further start strobes, have no effect until after `xfer_end`.
- R7: A word accepted at a clock edge appears on `out_data` with `out_valid`=1 right after that edge. While `out_valid`=1 and `out_ready`=0, both `out_valid` and `out_data` hold. No word is dropped or repeated.
- R8: `in_ready` is 1 only while busy, outside an `xfer_end` cycle, below `blk_cnt*blk_size/4` accepted words, and with the output slot empty or draining. A block count of 0 therefore accepts no words.
- R9: On `xfer_end`, `len_err` becomes 1 if the accepted count differs from the expected count and 0 otherwise. Any start strobe taken while idle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle strobe opening a transfer |
| xfer_end | input | 1 | One-cycle strobe closing a transfer |
| cmd_idx | input | 6 | Command index sampled at start |
| adtc | input | 1 | Command is an addressed data transfer |
| blk_cnt | input | BLK_CNT_W | Number of blocks |
| blk_size | input | BLK_SZ_W | Block size in bytes |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | 8*BYTES | Input word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts output word |
| out_data | output | 8*BYTES | Reordered output word |
| busy | output | 1 | Transfer open |
| size_err | output | 1 | Last start refused for misaligned block size |
| len_err | output | 1 | Last transfer ended with a wrong word count |

## Verification
The bench builds the unit with its default parameters: 12-bit block count and block size fields and 4-byte words. Every transform and length rule is therefore reachable with short payloads. One-word blocks, a zero block count, misaligned sizes of 2 and 6 bytes, and overrun attempts of a few extra words all fit in tens of cycles. Random output backpressure on every run exercises the hold and no-loss behaviour for each transform.

// File: rtl/sdr_pkg.sv
// Shared types and command constants for the payload reorder unit.
// Assumes 6-bit SD command indices.
package sdr_pkg;
    typedef enum logic [1:0] {
        SDR_PASS   = 2'd0,
        SDR_BITREV = 2'd1,
        SDR_BSWAP  = 2'd2
    } sdr_mode_e;

    localparam logic [5:0] CMD_SWITCH    = 6'd6;
    localparam logic [5:0] CMD_APP_STAT  = 6'd13;
    localparam logic [5:0] CMD_WR_BLKS   = 6'd22;
    localparam logic [5:0] CMD_WP_STAT   = 6'd30;
    localparam logic [5:0] CMD_CFG_READ  = 6'd51;
endpackage

// File: rtl/sdr_mode_decode.sv
// Maps the command index and the addressed-data flag to a transform mode.
// Purely combinational; the caller latches the result.
module sdr_mode_decode
    import sdr_pkg::*;
(
    input  logic [5:0]  cmd_idx,
    input  logic        adtc,
    output sdr_mode_e   mode
);
    // Select the transform for the special payload commands.
    always_comb begin
        mode = SDR_PASS;
        if (adtc) begin
            unique case (cmd_idx)
                CMD_SWITCH:                                       mode = SDR_BITREV;
                CMD_APP_STAT, CMD_WR_BLKS, CMD_WP_STAT, CMD_CFG_READ: mode = SDR_BSWAP;
                default:                                          mode = SDR_PASS;
            endcase
        end
    end
endmodule

// File: rtl/sdr_xfer_ctrl.sv
// Transfer control: latches mode and expected word count on start, counts
// accepted words, raises size and length errors.
// Assumes start and end are single-cycle strobes and take only occurs when room is high.
module sdr_xfer_ctrl
    import sdr_pkg::*;
#(
    parameter int BLK_CNT_W = 12,
    parameter int BLK_SZ_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 finish,
    input  sdr_mode_e            mode_in,
    input  logic [BLK_CNT_W-1:0] blk_cnt,
    input  logic [BLK_SZ_W-1:0]  blk_size,
    input  logic                 take,
    output logic                 busy,
    output sdr_mode_e            mode_q,
    output logic                 room,
    output logic                 size_err,
    output logic                 len_err
);
    localparam int PROD_W = BLK_CNT_W + BLK_SZ_W;
    localparam int WCNT_W = PROD_W - 2;

    logic [PROD_W-1:0] prod;
    logic [WCNT_W-1:0] exp_d, exp_q, cnt;

    // Expected payload length in words.
    always_comb begin
        prod  = PROD_W'(blk_cnt) * PROD_W'(blk_size);
        exp_d = prod[PROD_W-1:2];
    end

    // Input space exists while open, not closing, and below the expected count.
    assign room = busy && !finish && (cnt < exp_q);

    // Transfer state, word counter and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            mode_q   <= SDR_PASS;
            exp_q    <= '0;
            cnt      <= '0;
            size_err <= 1'b0;
            len_err  <= 1'b0;
        end else if (start && !busy) begin
            len_err <= 1'b0;
            if (blk_size[1:0] != 2'b00) begin
                size_err <= 1'b1;
            end else begin
                size_err <= 1'b0;
                busy     <= 1'b1;
                mode_q   <= mode_in;
                exp_q    <= exp_d;
                cnt      <= '0;
            end
        end else if (finish && busy) begin
            busy    <= 1'b0;
            len_err <= (cnt != exp_q);
        end else if (take) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R5
    size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && blk_size[1:0] != 2'b00) |=> (size_err && !busy));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !finish) |=> $stable(mode_q));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= exp_q));

    // R9
    len_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && finish && cnt != exp_q) |=> len_err);
endmodule

// File: rtl/sdr_word_stage.sv
// One registered output stage applying the selected transform to each word.
// Assumes the caller raises take only when slot_free is high.
module sdr_word_stage
    import sdr_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sdr_mode_e          mode,
    input  logic               take,
    input  logic [8*BYTES-1:0] in_data,
    output logic               slot_free,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [8*BYTES-1:0] out_data
);
    localparam int W = 8 * BYTES;

    logic [W-1:0] rev_w, swp_w, xf_w;

    // Per-byte bit reversal and whole-word byte swap networks.
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        for (genvar k = 0; k < 8; k++) begin : g_bit
            assign rev_w[8*b + k] = in_data[8*b + 7 - k];
        end
        assign swp_w[8*b +: 8] = in_data[8*(BYTES-1-b) +: 8];
    end

    // Pick the transform for the latched mode.
    always_comb begin
        unique case (mode)
            SDR_BITREV: xf_w = rev_w;
            SDR_BSWAP:  xf_w = swp_w;
            default:    xf_w = in_data;
        endcase
    end

    assign slot_free = !out_valid || out_ready;

    // Output register: load on accept, empty on drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= xf_w;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(take));
endmodule

// File: rtl/sd_payload_reorder.sv
// Top of the SD special-command payload reorder unit: decodes the command,
// controls the transfer and streams words through one registered transform.
// Assumes xfer_start and xfer_end are one-cycle strobes.
module sd_payload_reorder
    import sdr_pkg::*;
#(
    parameter int BLK_CNT_W = 12,
    parameter int BLK_SZ_W  = 12,
    parameter int BYTES     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_start,
    input  logic                 xfer_end,
    input  logic [5:0]           cmd_idx,
    input  logic                 adtc,
    input  logic [BLK_CNT_W-1:0] blk_cnt,
    input  logic [BLK_SZ_W-1:0]  blk_size,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [8*BYTES-1:0]   in_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [8*BYTES-1:0]   out_data,
    output logic                 busy,
    output logic                 size_err,
    output logic                 len_err
);
    sdr_mode_e mode_dec, mode_q;
    logic      room, slot_free, take;

    // Handshake join of transfer room and output space.
    assign in_ready = room && slot_free;
    assign take     = in_valid && in_ready;

    sdr_mode_decode u_dec (
        .cmd_idx (cmd_idx),
        .adtc    (adtc),
        .mode    (mode_dec)
    );

    sdr_xfer_ctrl #(
        .BLK_CNT_W (BLK_CNT_W),
        .BLK_SZ_W  (BLK_SZ_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (xfer_start),
        .finish   (xfer_end),
        .mode_in  (mode_dec),
        .blk_cnt  (blk_cnt),
        .blk_size (blk_size),
        .take     (take),
        .busy     (busy),
        .mode_q   (mode_q),
        .room     (room),
        .size_err (size_err),
        .len_err  (len_err)
    );

    sdr_word_stage #(
        .BYTES (BYTES)
    ) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_q),
        .take      (take),
        .in_data   (in_data),
        .slot_free (slot_free),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );
endmodule

// File: tb/sd_payload_reorder_tb.sv
module sd_payload_reorder_tb;
    localparam int T = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_end = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic        adtc = 1'b0;
    logic [11:0] blk_cnt = '0, blk_size = '0;
    logic        in_valid = 1'b0, in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid, out_ready = 1'b0;
    logic [31:0] out_data;
    logic        busy, size_err, len_err;

    int checks = 0, failures = 0;
    bit rdy_force = 1'b1;
    bit done = 1'b0;

    always #(T/2) clk = ~clk;

    sd_payload_reorder u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_end(xfer_end),
        .cmd_idx(cmd_idx), .adtc(adtc), .blk_cnt(blk_cnt), .blk_size(blk_size),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .busy(busy), .size_err(size_err), .len_err(len_err)
    );

    // Behavioural reference: 0 pass, 1 bit reverse per byte, 2 byte swap.
    function automatic int ref_mode(input int idx, input bit dt);
        if (!dt) return 0;
        if (idx == 6) return 1;
        if (idx == 13 || idx == 22 || idx == 30 || idx == 51) return 2;
        return 0;
    endfunction

    function automatic logic [31:0] ref_xf(input int m, input logic [31:0] w);
        logic [31:0] r;
        r = w;
        if (m == 1) begin
            for (int i = 0; i < 32; i++) r[(i/8)*8 + 7 - (i%8)] = w[i];
        end else if (m == 2) begin
            for (int i = 0; i < 4; i++) r[8*(3-i) +: 8] = w[8*i +: 8];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model state.
    bit          m_busy = 0, m_size = 0, m_len = 0;
    int          m_mode = 0, m_exp = 0, m_cnt = 0;
    logic [31:0] q_data[$];
    int          q_tag[$];

    // Cycle-by-cycle comparison, sampled between edges.
    initial begin
        forever begin
            bit exp_rdy, push, pop;
            @(negedge clk);
            #5;
            if (done) break;
            if (!rst_n) begin
                m_busy = 0; m_size = 0; m_len = 0; m_mode = 0; m_exp = 0; m_cnt = 0;
                q_data.delete(); q_tag.delete();
                continue;
            end
            exp_rdy = m_busy && !xfer_end && (m_cnt < m_exp) && (q_data.size() == 0 || out_ready);
            chk("R8 in_ready", {31'b0, in_ready}, {31'b0, exp_rdy});
            chk("R7 out_valid", {31'b0, out_valid}, {31'b0, q_data.size() > 0});
            if (out_valid && q_data.size() > 0) begin
                if (q_tag[0] == 1)      chk("R2 bit-reversed word", out_data, q_data[0]);
                else if (q_tag[0] == 2) chk("R3 byte-swapped word", out_data, q_data[0]);
                else                    chk("R4 pass-through word", out_data, q_data[0]);
            end
            chk("R6 busy", {31'b0, busy}, {31'b0, m_busy});
            chk("R5 size_err", {31'b0, size_err}, {31'b0, m_size});
            chk("R9 len_err", {31'b0, len_err}, {31'b0, m_len});
            // Advance the model across the coming edge.
            pop  = (q_data.size() > 0) && out_ready;
            push = in_valid && exp_rdy;
            if (pop) begin void'(q_data.pop_front()); void'(q_tag.pop_front()); end
            if (push) begin q_data.push_back(ref_xf(m_mode, in_data)); q_tag.push_back(m_mode); end
            if (xfer_start && !m_busy) begin
                m_len = 0;
                if (blk_size % 4 != 0) m_size = 1;
                else begin
                    m_size = 0; m_busy = 1; m_cnt = 0;
                    m_mode = ref_mode(cmd_idx, adtc);
                    m_exp  = blk_cnt * blk_size / 4;
                end
            end else if (xfer_end && m_busy) begin
                m_busy = 0;
                m_len  = (m_cnt != m_exp);
            end
            if (push) m_cnt++;
        end
    end

    // Downstream readiness with random backpressure.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = rdy_force ? 1'b1 : ($urandom % 4 != 0);
        end
    end

    task automatic open_xfer(input int idx, input bit dt, input int nb, input int sz);
        xfer_start = 1; cmd_idx = 6'(idx); adtc = dt; blk_cnt = 12'(nb); blk_size = 12'(sz);
        @(negedge clk);
        xfer_start = 0;
    endtask

    task automatic close_xfer();
        xfer_end = 1;
        @(negedge clk);
        xfer_end = 0;
    endtask

    task automatic send_word(input logic [31:0] w, input int lim);
        bit ok = 0;
        in_valid = 1; in_data = w;
        for (int i = 0; i < lim && !ok; i++) begin
            #5;
            if (in_ready) ok = 1;
            @(negedge clk);
        end
        in_valid = 0;
    endtask

    task automatic run_xfer(input int idx, input bit dt, input int nb, input int sz, input int nw);
        open_xfer(idx, dt, nb, sz);
        for (int i = 0; i < nw; i++) send_word($urandom, 20);
        repeat (3) @(negedge clk);
        close_xfer();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #5;
        // R1: idle state after reset
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 in_ready", {31'b0, in_ready}, 32'd0);
        chk("R1 errors", {30'b0, size_err, len_err}, 32'd0);
        @(negedge clk);
        rdy_force = 0;
        run_xfer(6, 1, 1, 16, 4);     // R2
        run_xfer(51, 1, 2, 8, 4);     // R3
        run_xfer(13, 1, 2, 4, 2);     // R3
        run_xfer(22, 1, 1, 4, 1);     // R3
        run_xfer(30, 1, 1, 8, 2);     // R3
        run_xfer(17, 1, 1, 12, 3);    // R4
        run_xfer(6, 0, 1, 8, 2);      // R4 flag low
        // R5: misaligned sizes refused, then cleared by a good start
        open_xfer(6, 1, 1, 6);
        send_word(32'h1234_5678, 4);
        repeat (2) @(negedge clk);
        open_xfer(6, 1, 1, 2);
        repeat (2) @(negedge clk);
        run_xfer(13, 1, 1, 4, 1);
        // R6: index and start changes mid-transfer ignored
        open_xfer(22, 1, 1, 16);
        send_word($urandom, 20);
        cmd_idx = 6'd6; xfer_start = 1; blk_cnt = 12'd9; blk_size = 12'd4;
        @(negedge clk);
        xfer_start = 0;
        for (int i = 0; i < 3; i++) send_word($urandom, 20);
        repeat (3) @(negedge clk);
        close_xfer();
        repeat (2) @(negedge clk);
        // R8: overrun refused, zero-block transfer accepts nothing
        run_xfer(51, 1, 1, 8, 5);
        run_xfer(17, 1, 0, 8, 2);
        // R9: short transfer flags length error, next start clears it
        run_xfer(6, 1, 2, 8, 2);
        run_xfer(17, 1, 1, 4, 1);
        rdy_force = 1;
        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule